// File: doc/BRIEF.md
# Dual Retriggerable Gated One-Shot

This block is a clocked pulse stretcher with two channels. It stands in for a resistor/capacitor timed monostable. Each channel watches three asynchronous inputs:

- a trigger that fires on its falling edge;
- a trigger that fires on its rising edge;
- an active-low clear.

A qualifying edge starts a pulse. The pulse lasts a programmable number of clock cycles, and the length is set separately for each channel. Each edge is qualified by the levels of the other two inputs. Releasing the clear is itself a trigger when the two edge inputs sit in their enabling levels.

Each channel drives a registered pulse output and its registered complement. A qualifying trigger that arrives during a running pulse restarts the full count, so the pulse is stretched. Holding the clear low ends the pulse and keeps the channel idle.

Every input passes through a two-flop synchroniser before edge detection. This gives a fixed latency. The channels share only the clock and the reset.

Top module: `dual_oneshot`

## Requirements
- R1: A falling edge on `fall_trig` starts a pulse when `rise_trig` is high and `clr_n` is high at that time.
- R2: A rising edge on `rise_trig` starts a pulse when `fall_trig` is low and `clr_n` is high at that time.
- R3: A rising edge on `clr_n` starts a pulse when `fall_trig` is low and `rise_trig` is high at that time.
- R4: A low level on `clr_n` ends any running pulse. `pulse` is low and `pulse_n` is high by the second clock edge after the low level is first sampled. If `clr_n` falls in the same cycle as an edge on `fall_trig` or `rise_trig`, no pulse starts.
- R5: With a width of N > 0, `pulse` goes high at the second clock edge after the input change is first sampled. It then stays high for exactly N cycles.
- R6: A qualifying trigger during a pulse reloads the full width, measured from the newer trigger. The total high time is the trigger spacing plus N.
- R7: A trigger taken while the channel's width is 0 produces no pulse.
- R8: While `fall_trig` is held high, toggling `rise_trig` starts no pulse. While `rise_trig` is held low, toggling `fall_trig` starts no pulse.
- R9: `pulse_n` is always the complement of `pulse`. During and right after reset, `pulse` is low and `pulse_n` is high.
- R10: The two channels are independent. Activity on one channel never changes the outputs of the other.
- R11: Reset clears the synchroniser and edge history. For the first three cycles after reset, no edge is detected, so input levels present at reset never start a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fall_trig | input | NCH | Falling-edge trigger, one bit per channel |
| rise_trig | input | NCH | Rising-edge trigger, one bit per channel |
| clr_n | input | NCH | Active-low clear, one bit per channel; its rising edge is also a trigger |
| pulse_len | input | NCH x LW | Pulse width in clock cycles, per channel |
| pulse | output | NCH | Pulse output, high while the one-shot is active |
| pulse_n | output | NCH | Complement of `pulse` |

## Verification
Directed sequences drive each trigger source in turn:

- once with its qualifying levels present, which shows it starts a pulse;
- once with a blocking level present, which shows the gating rather than the edge alone decides.

A retrigger spaced four cycles after the first edge distinguishes a full reload from a pulse that merely continues or that restarts only once. A clear dropped in mid-pulse, and a clear dropped in the same cycle as a trigger, separate clear priority from an ordinary retrigger.

Reset is asserted while the inputs sit at their triggering levels, which exposes any false edge taken from the reset values. Long random runs on both channels at once, with varying widths including zero, are compared cycle by cycle with a bench model. These runs catch cross-channel leakage and counter off-by-one errors.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  // Which of the three trigger sources qualified in a given cycle
  typedef struct packed {
    logic a_fall;
    logic b_rise;
    logic clr_rise;
  } trig_src_t;
endpackage

// File: rtl/osh_sync.sv
module osh_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/osh_trig.sv
module osh_trig #(
  parameter int WARM = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  input  logic c_s,
  output logic fire
);
  import oneshot_pkg::*;

  logic            a_p, b_p, c_p;
  logic [WARM-1:0] warm;
  logic            en;
  trig_src_t       src;

  // Edge history is only trusted once the synchroniser has refilled
  always_ff @(posedge clk) begin
    if (rst) begin
      a_p  <= 1'b0;
      b_p  <= 1'b0;
      c_p  <= 1'b0;
      warm <= '0;
    end else begin
      a_p  <= a_s;
      b_p  <= b_s;
      c_p  <= c_s;
      warm <= {warm[WARM-2:0], 1'b1};
    end
  end

  assign en = warm[WARM-1];

  always_comb begin
    src.a_fall   = en &  a_p & ~a_s &  b_s & c_s;
    src.b_rise   = en & ~b_p &  b_s & ~a_s & c_s;
    src.clr_rise = en & ~c_p &  c_s & ~a_s & b_s;
  end

  assign fire = |src;
endmodule

// File: rtl/osh_timer.sv
module osh_timer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_lvl,
  input  logic          fire,
  input  logic [LW-1:0] len,
  output logic          q,
  output logic          q_n
);
  logic [LW-1:0] cnt, cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (!clr_lvl)         cnt_nx = '0;
    else if (fire)        cnt_nx = len;
    else if (cnt != '0)   cnt_nx = cnt - LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      q   <= (cnt_nx != '0);
      q_n <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int NCH         = 2,
  parameter int LW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         fall_trig,
  input  logic [NCH-1:0]         rise_trig,
  input  logic [NCH-1:0]         clr_n,
  input  logic [NCH-1:0][LW-1:0] pulse_len,
  output logic [NCH-1:0]         pulse,
  output logic [NCH-1:0]         pulse_n
);
  localparam int WARM = SYNC_STAGES + 1;

  logic [NCH-1:0] clr_sync;
  logic [NCH-1:0] fire_vec;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [2:0] raw, synced;

      assign raw          = {fall_trig[ch], rise_trig[ch], clr_n[ch]};
      assign clr_sync[ch] = synced[0];

      osh_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
      );

      osh_trig #(.WARM(WARM)) u_trig (
        .clk  (clk),
        .rst  (rst),
        .a_s  (synced[2]),
        .b_s  (synced[1]),
        .c_s  (synced[0]),
        .fire (fire_vec[ch])
      );

      osh_timer #(.LW(LW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr_lvl (synced[0]),
        .fire    (fire_vec[ch]),
        .len     (pulse_len[ch]),
        .q       (pulse[ch]),
        .q_n     (pulse_n[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/dual_oneshot_chk.sv
module dual_oneshot_chk #(
  parameter int NCH = 2,
  parameter int LW  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCH-1:0]         clr_sync,
  input logic [NCH-1:0]         fire_vec,
  input logic [NCH-1:0][LW-1:0] pulse_len,
  input logic [NCH-1:0]         pulse,
  input logic [NCH-1:0]         pulse_n
);
  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
      AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        pulse[ch] == ~pulse_n[ch]);                                              // R9
      AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!pulse[ch] && pulse_n[ch]));                                    // R9
      AST_CLEAR_KILLS: assert property (@(posedge clk) disable iff (rst)
        !clr_sync[ch] |=> !pulse[ch]);                                           // R4
      AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (fire_vec[ch] && clr_sync[ch] && pulse_len[ch] != '0) |=> pulse[ch]);    // R5
      AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (fire_vec[ch] && pulse_len[ch] == '0) |=> !pulse[ch]);                   // R7
      AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse[ch]) |-> $past(fire_vec[ch]));                               // R1
    end
  endgenerate
endmodule

bind dual_oneshot dual_oneshot_chk #(.NCH(NCH), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_sync  (clr_sync),
  .fire_vec  (fire_vec),
  .pulse_len (pulse_len),
  .pulse     (pulse),
  .pulse_n   (pulse_n)
);

// File: tb/dual_oneshot_bench.sv
module dual_oneshot_bench;
  localparam int NCH = 2;
  localparam int LW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NCH-1:0]         fall_trig, rise_trig, clr_n;
  logic [NCH-1:0][LW-1:0] pulse_len;
  logic [NCH-1:0]         pulse, pulse_n;

  dual_oneshot #(.NCH(NCH), .LW(LW)) u_dual_oneshot (
    .clk(clk), .rst(rst), .fall_trig(fall_trig), .rise_trig(rise_trig),
    .clr_n(clr_n), .pulse_len(pulse_len), .pulse(pulse), .pulse_n(pulse_n)
  );

  int    vectors = 0, fails = 0, cyc = 0;
  string cur_req = "R9";
  bit    checking = 0, done = 0;

  // Requirement-level model: 2-cycle sync, edge history, 3-cycle warm-up
  logic a1[NCH], a2[NCH], ap[NCH], b1[NCH], b2[NCH], bp[NCH], c1[NCH], c2[NCH], cp[NCH];
  int   warm[NCH], cnt[NCH];
  logic eq[NCH];

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin
      a1[ch]=0; a2[ch]=0; ap[ch]=0; b1[ch]=0; b2[ch]=0; bp[ch]=0;
      c1[ch]=0; c2[ch]=0; cp[ch]=0; warm[ch]=0; cnt[ch]=0; eq[ch]=0;
    end
  end

  function automatic bit qualifies(bit en, bit pa, bit a, bit pb, bit b, bit pc, bit c);
    return en && ((pa && !a && b && c) || (!pb && b && !a && c) || (!pc && c && !a && b));
  endfunction

  always @(posedge clk) begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (rst) begin
        a1[ch]=0; a2[ch]=0; ap[ch]=0; b1[ch]=0; b2[ch]=0; bp[ch]=0;
        c1[ch]=0; c2[ch]=0; cp[ch]=0; warm[ch]=0; cnt[ch]=0;
      end else begin
        bit f;
        f = qualifies(warm[ch] >= 3, ap[ch], a2[ch], bp[ch], b2[ch], cp[ch], c2[ch]);
        if (!c2[ch])          cnt[ch] = 0;
        else if (f)           cnt[ch] = int'(pulse_len[ch]);
        else if (cnt[ch] > 0) cnt[ch] = cnt[ch] - 1;
        ap[ch]=a2[ch]; a2[ch]=a1[ch]; a1[ch]=fall_trig[ch];
        bp[ch]=b2[ch]; b2[ch]=b1[ch]; b1[ch]=rise_trig[ch];
        cp[ch]=c2[ch]; c2[ch]=c1[ch]; c1[ch]=clr_n[ch];
        if (warm[ch] < 3) warm[ch] = warm[ch] + 1;
      end
      eq[ch] = (cnt[ch] != 0);
    end
  end

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checking && !done) begin
      for (int ch = 0; ch < NCH; ch++) begin
        vectors++;
        if (pulse[ch] !== eq[ch] || pulse_n[ch] !== ~eq[ch]) begin
          fails++;
          $display("FAIL %s ch%0d: pulse/pulse_n=%b%b expected %b%b", cur_req, ch,
                   pulse[ch], pulse_n[ch], eq[ch], ~eq[ch]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      finish_sim();
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // Count high cycles of a channel over a window
  task automatic count_high(int ch, int n, output int c, output int other);
    c = 0; other = 0;
    repeat (n) begin
      @(negedge clk);
      if (pulse[ch]) c++;
      if (pulse[1-ch]) other++;
    end
  endtask

  initial begin
    int c, o, o_total;
    o_total = 0;
    fall_trig = '0; rise_trig = '1; clr_n = '1;   // triggering levels during reset (R11)
    pulse_len[0] = LW'(5); pulse_len[1] = LW'(4);
    @(posedge clk);
    checking = 1;
    wait_n(3);
    cur_req = "R9";
    chk("R9 reset pulse", int'(pulse), 0);
    chk("R9 reset pulse_n", int'(pulse_n), 3);
    rst = 1'b0;
    cur_req = "R11";
    count_high(0, 8, c, o);
    chk("R11 no false edge ch0", c, 0);
    chk("R11 no false edge ch1", o, 0);

    // Channel 1 parked inhibited while channel 0 is exercised
    fall_trig[1] = 1'b1; rise_trig[1] = 1'b0;
    wait_n(4);

    // R1 / R5: single falling-edge trigger, width 5
    cur_req = "R1";
    fall_trig[0] = 1'b1; wait_n(4);
    fall_trig[0] = 1'b0;
    count_high(0, 20, c, o); o_total += o;
    chk("R5 width 5 via falling trigger (R1)", c, 5);

    // R6: retrigger four cycles after the first edge
    cur_req = "R6";
    fall_trig[0] = 1'b1; wait_n(4);
    fall_trig[0] = 1'b0;
    c = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (pulse[0]) c++;
      if (pulse[1]) o_total++;
      if (i == 2) fall_trig[0] = 1'b1;
      if (i == 3) fall_trig[0] = 1'b0;
    end
    chk("R6 retrigger stretch", c, 9);

    // R2: rising trigger, width 3
    cur_req = "R2";
    pulse_len[0] = LW'(3);
    rise_trig[0] = 1'b0; wait_n(4);
    rise_trig[0] = 1'b1;
    count_high(0, 12, c, o); o_total += o;
    chk("R2 rising trigger width 3", c, 3);

    // R8: inhibit by fall_trig high, then by rise_trig low
    cur_req = "R8";
    fall_trig[0] = 1'b1; wait_n(3);
    rise_trig[0] = 1'b0; wait_n(3); rise_trig[0] = 1'b1; wait_n(3); rise_trig[0] = 1'b0;
    count_high(0, 10, c, o); o_total += o;
    chk("R8 rise_trig toggled while fall_trig high", c, 0);
    fall_trig[0] = 1'b0; wait_n(3); fall_trig[0] = 1'b1; wait_n(3); fall_trig[0] = 1'b0;
    count_high(0, 10, c, o); o_total += o;
    chk("R8 fall_trig toggled while rise_trig low", c, 0);

    // R3: clear release with fall low, rise high
    cur_req = "R3";
    rise_trig[0] = 1'b1; clr_n[0] = 1'b0; wait_n(5);
    clr_n[0] = 1'b1;
    count_high(0, 12, c, o); o_total += o;
    chk("R3 clear release trigger", c, 3);

    // R4: clear in mid-pulse
    cur_req = "R4";
    pulse_len[0] = LW'(20);
    rise_trig[0] = 1'b0; wait_n(4);
    rise_trig[0] = 1'b1;
    c = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pulse[0]) c++;
      if (pulse[1]) o_total++;
      if (i == 4) clr_n[0] = 1'b0;
    end
    chk("R4 clear truncates pulse", c, 5);
    rise_trig[0] = 1'b0; wait_n(4); clr_n[0] = 1'b1; wait_n(4);
    // R4: clear falls together with a falling trigger
    fall_trig[0] = 1'b1; rise_trig[0] = 1'b1; wait_n(4);
    fall_trig[0] = 1'b0; clr_n[0] = 1'b0;
    count_high(0, 10, c, o); o_total += o;
    chk("R4 clear wins over simultaneous edge", c, 0);
    rise_trig[0] = 1'b0; wait_n(4); clr_n[0] = 1'b1; wait_n(4);

    // R7: zero width
    cur_req = "R7";
    pulse_len[0] = '0;
    rise_trig[0] = 1'b1;
    count_high(0, 10, c, o); o_total += o;
    chk("R7 zero width no pulse", c, 0);
    chk("R10 idle channel untouched", o_total, 0);

    // R10: both channels random, compared every cycle against the model
    cur_req = "R10";
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
        int r;
        r = int'($urandom_range(0, 29));
        if (r == 0)      fall_trig[ch] = ~fall_trig[ch];
        else if (r == 1) rise_trig[ch] = ~rise_trig[ch];
        else if (r == 2 && $urandom_range(0, 2) == 0) clr_n[ch] = ~clr_n[ch];
        else if (r == 3 && $urandom_range(0, 3) == 0) pulse_len[ch] = LW'($urandom_range(0, 12));
      end
    end
    wait_n(20);
    finish_sim();
  end
endmodule